// File: doc/BRIEF.md
# Central Bus Arbiter with Overlapped Grant Hand-over

This block is the central arbiter of a shared parallel bus with several masters. Each master has a private active-low request line into the arbiter and a private active-low grant line out of it. The arbiter also watches the two shared active-low bus-activity signals: the cycle-frame strobe and the initiator-ready strobe. It can therefore decide who goes next while another master is still moving data. The bus counts as idle only when both strobes are high.

A master that sees its grant may begin a transaction only from an idle bus. Taking a grant away from the master that currently drives the bus tells that master it has been preempted. It finishes its transfer, and the arbiter does not cut it off. Requesters are served in rotating order. The rotation restarts just after the master that most recently began a transaction. If nobody requests, the grant rests on a fixed default master. A master that holds the grant on an idle bus but never starts loses the grant after a bounded wait, and the turn moves on.

Top module: `bus_arbiter`

## Requirements
- R1: While `rst` is high, every bit of `gnt_n` is 1 (no grant).
- R2: At most one bit of `gnt_n` is 0 in any cycle.
- R3: When the grant moves from one master to a different master, at least one cycle with all `gnt_n` bits at 1 separates the two grants.
- R4: With no request asserted, the grant settles on master `PARK_AGENT` (default 0), so `gnt_n` reads 4'b1110 with the defaults.
- R5: The next grant goes to the first requesting master found by scanning upward, wrapping at the top, starting just after the most recent transaction starter. After reset the scan starts at master 0.
- R6: The grant can move to another requester while the frame strobe is still low. This withdraws the grant from the current bus driver without any change to the bus strobes.
- R7: A transaction start is a cycle in which the frame strobe is sampled low right after a cycle with both strobes high. The master granted in that start cycle becomes the most recent starter.
- R8: If the granted master keeps requesting through 16 consecutive idle cycles without starting, the arbiter removes its grant and treats that master as the most recent starter.
- R9: A master that requests continuously is granted within a bounded number of cycles (no starvation).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | N_AGENTS | Active-low request, one per master |
| frame_n | input | 1 | Shared active-low cycle-frame strobe |
| irdy_n | input | 1 | Shared active-low initiator-ready strobe |
| gnt_n | output | N_AGENTS | Registered active-low grant, one per master |

## Verification
Every grant decision is registered, so inputs applied in one cycle show on `gnt_n` one rising edge later. A hand-over between two masters takes two edges: one to clear the old grant and one to assert the new one. The bench drives inputs just after a falling edge and reads `gnt_n` at the next falling edge, which is exactly one rising edge later. Each reading is compared against a cycle model held in the bench. The idle-timeout case expects the grant to be visible for exactly 16 readings and absent on the 17th. The preemption case expects the new master's grant two readings after the frame strobe first falls, while that strobe is still low.

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] win
);
  int j;
  always_comb begin
    found = 1'b0;
    win   = '0;
    j     = 0;
    for (int k = 1; k <= N; k++) begin
      j = (int'(last) + k) % N;
      if (!found && req[j]) begin
        found = 1'b1;
        win   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/arb_idle_timer.sv
module arb_idle_timer #(
  parameter int LIMIT = 16,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic expired
);
  logic [CW-1:0] cnt;

  assign expired = en && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !en)   cnt <= '0;
    else if (expired) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R8: the wait count never reaches the limit itself
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(LIMIT));
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int N_AGENTS   = 4,
  parameter int PARK_AGENT = 0,
  parameter int IDLE_LIMIT = 16,
  localparam int IW        = $clog2(N_AGENTS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_AGENTS-1:0] req_n,
  input  logic                frame_n,
  input  logic                irdy_n,
  output logic [N_AGENTS-1:0] gnt_n
);
  logic [N_AGENTS-1:0] gnt_q;
  logic [IW-1:0]       last_q;
  logic                idle_d;
  logic [N_AGENTS-1:0] req;
  logic                idle, start, gnt_any, hold_en, expire, found;
  logic [IW-1:0]       gidx, pick, nxt;

  function automatic logic [IW-1:0] enc(input logic [N_AGENTS-1:0] v);
    enc = '0;
    for (int i = 0; i < N_AGENTS; i++) if (v[i]) enc = IW'(i);
  endfunction

  assign req     = ~req_n;
  assign idle    = frame_n & irdy_n;
  assign start   = idle_d & ~frame_n;
  assign gnt_any = |gnt_q;
  assign gidx    = enc(gnt_q);
  assign nxt     = found ? pick : IW'(PARK_AGENT);
  assign hold_en = gnt_any & idle & req[gidx];
  assign gnt_n   = ~gnt_q;

  arb_rr_pick #(.N(N_AGENTS), .IW(IW)) u_pick (
    .req(req), .last(last_q), .found(found), .win(pick));

  arb_idle_timer #(.LIMIT(IDLE_LIMIT)) u_timer (
    .clk(clk), .rst(rst), .en(hold_en), .expired(expire));

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= '0;
      last_q <= IW'(N_AGENTS - 1);
      idle_d <= 1'b1;
    end else begin
      idle_d <= idle;
      if (start && gnt_any) last_q <= gidx;
      else if (expire)      last_q <= gidx;
      if (!gnt_any)                  gnt_q <= N_AGENTS'(1) << nxt;
      else if (expire || nxt != gidx) gnt_q <= '0;
    end
  end

  // R2: never two grants at once
  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q));
  // R3: a live grant either stays or drops to none
  p_gap_r3: assert property (@(posedge clk) disable iff (rst)
    gnt_any |=> (gnt_q == '0 || gnt_q == $past(gnt_q)));
  // R4: empty grant with no requests parks on the default master
  p_park_r4: assert property (@(posedge clk) disable iff (rst)
    (!gnt_any && req == '0) |=> gnt_q == (N_AGENTS'(1) << PARK_AGENT));
  // R8: an expired wait withdraws the grant
  p_expire_r8: assert property (@(posedge clk) disable iff (rst)
    expire |=> gnt_q == '0);
endmodule

// File: tb/bus_arbiter_test.sv
module bus_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req_n = '1;
  logic frame_n = 1'b1, irdy_n = 1'b1;
  logic [N-1:0] gnt_n;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  int m_gnt, m_ptr, m_cnt;
  bit m_idle_d;
  int og, prev_og;
  int waitc [N];
  int maxwait;
  int hidden_moves;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_arbiter #(.N_AGENTS(N)) uut (
    .clk(clk), .rst(rst), .req_n(req_n), .frame_n(frame_n),
    .irdy_n(irdy_n), .gnt_n(gnt_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_gnt = -1; m_ptr = N - 1; m_cnt = 0; m_idle_d = 1'b1; prev_og = -1;
  endtask

  task automatic model_step(input logic [N-1:0] r, input logic fr, input logic ir);
    bit idle, st, hold, ex;
    int nxt, ng, np;
    idle = fr & ir;
    st   = m_idle_d & ~fr;
    nxt  = 0;
    for (int k = N; k >= 1; k--) if (r[(m_ptr + k) % N]) nxt = (m_ptr + k) % N;
    if (r == '0) nxt = 0;
    hold = (m_gnt >= 0) && idle && r[m_gnt];
    ex   = hold && (m_cnt == 15);
    np = m_ptr;
    if (st && m_gnt >= 0) np = m_gnt;
    else if (ex) np = m_gnt;
    if (m_gnt < 0) ng = nxt;
    else if (ex || nxt != m_gnt) ng = -1;
    else ng = m_gnt;
    m_cnt = (!hold || ex) ? 0 : m_cnt + 1;
    m_idle_d = idle; m_ptr = np; m_gnt = ng;
  endtask

  task automatic tick(input logic [N-1:0] r, input logic fr, input logic ir, input string tag);
    req_n = ~r; frame_n = fr; irdy_n = ir;
    model_step(r, fr, ir);
    @(negedge clk);
    og = -1;
    for (int i = 0; i < N; i++) if (!gnt_n[i]) og = i;
    chk($countones(~gnt_n) <= 1, "R2 one grant", $countones(~gnt_n), 1);
    chk(og == m_gnt, tag, og, m_gnt);
    if (prev_og >= 0 && og >= 0) chk(og == prev_og, "R3 gap on hand-over", og, prev_og);
    if (og >= 0 && og != prev_og && !fr) hidden_moves++;
    for (int i = 0; i < N; i++) begin
      if (r[i] && og != i) waitc[i]++; else waitc[i] = 0;
      if (waitc[i] > maxwait) maxwait = waitc[i];
    end
    prev_og = og;
  endtask

  task automatic do_reset();
    rst = 1'b1; req_n = '1; frame_n = 1'b1; irdy_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(gnt_n == '1, "R1 no grant in reset", int'(gnt_n), 15);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    int run, seen, bus_left;
    bit last_idle, saw2, saw0;
    logic [N-1:0] r;
    logic fr, ir;
    void'($urandom(32'd20240611));
    maxwait = 0; hidden_moves = 0;
    for (int i = 0; i < N; i++) waitc[i] = 0;
    @(negedge clk);
    do_reset();

    // R4: parking with no requests
    tick('0, 1, 1, "R4 model");
    chk(gnt_n == 4'b1110, "R4 park on master 0", int'(gnt_n), 14);
    tick('0, 1, 1, "R4 model");

    // R8: master 2 requests but never starts
    run = 0; seen = 0;
    for (int c = 0; c < 40; c++) begin
      tick(4'b0100, 1, 1, "R8 model");
      if (og == 2) begin run++; seen = 1; end
      else if (seen) break;
    end
    chk(run == 16, "R8 grant held 16 idle clocks", run, 16);
    chk(og == -1, "R8 grant withdrawn", og, -1);

    // R5/R6/R7: directed preemption
    do_reset();
    for (int c = 0; c < 4; c++) tick(4'b1010, 1, 1, "R5 model");
    chk(og == 1, "R5 first pick after reset", og, 1);
    saw2 = 0; saw0 = 0;
    for (int c = 0; c < 8; c++) begin
      tick(4'b1111, 1'b0, 1'b0, "R6 model");
      if (og == 2) saw2 = 1;
      if (og == 0) saw0 = 1;
    end
    chk(saw2, "R6 grant moves while frame low", saw2, 1);
    chk(!saw0, "R7 starter 1 makes scan skip master 0", saw0, 0);
    tick(4'b1111, 1, 0, "R6 model");
    tick(4'b1111, 1, 1, "R6 model");

    // random traffic, all requirements against the model
    do_reset();
    r = '0; bus_left = 0; last_idle = 1; prev_og = -1;
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++) if ($urandom % 8 == 0) r[i] = ~r[i];
      if (bus_left == 0 && last_idle && prev_og >= 0 && r[prev_og] && ($urandom % 4 != 0))
        bus_left = 2 + int'($urandom % 6);
      fr = (bus_left > 1) ? 1'b0 : 1'b1;
      ir = (bus_left > 0) ? 1'b0 : 1'b1;
      last_idle = fr & ir;
      if (bus_left > 0) bus_left--;
      tick(r, fr, ir, "R5 model");
    end
    chk(hidden_moves > 0, "R6 grants issued during busy bus", hidden_moves, 1);
    chk(maxwait <= 200, "R9 bounded wait", maxwait, 200);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule